// File: doc/BRIEF.md
# Job Ring Doorbell and Completion Interrupt Controller

This block keeps the counts and indices for a pair of circular job rings. Software places job descriptors in an input ring and announces them by writing a count to a doorbell register. Hardware writes results into an output ring, and software hands those slots back by writing a removal count. The block dispatches pending input jobs to an execution engine, one per cycle, through a single issue pulse. The engine reports each finished job through a completion strobe.

The block raises an interrupt line on job completion. Completion interrupts can be coalesced, either by the number of completions since the last interrupt or by a timer. A doorbell write that would overrun either ring is rejected and reported with a typed error code. A two-step reset command first drains the jobs in flight and reports the halt state, then clears the ring state.

Top module: `job_ring_ctrl`

## Requirements
- R1: Register map (word addresses): 0 config, 1 input ring size, 2 output ring size, 3 add jobs on write / input room on read, 4 remove jobs on write / full output slots on read, 5 interrupt status, 6 input read index, 7 output write index, 8 command. Ring sizes are 10-bit fields. Input room reads as input size minus jobs pending, and reads 0 after reset.
- R2: While jobs are pending, one job is issued per cycle. Each issue lowers the pending count and advances the input read index, which wraps to 0 at the input ring size. No job issues while jobs in flight plus full output slots would reach the output ring size.
- R3: Each completion strobe with a job in flight adds one full output slot and advances the output write index, which wraps to 0 at the output ring size. A valid remove write subtracts its count from the full slots.
- R4: Status layout: bit 0 completion interrupt, bit 1 error flag, bits 3:2 halt state, bits 11:8 error type. Writing 1 to bit 0 or bit 1 clears that flag, and clearing bit 1 also clears the type. The irq output follows (bit 0 OR bit 1) one cycle later unless masked.
- R5: An add count larger than the input room is rejected, leaving the counters unchanged, and sets the error flag with type 9.
- R6: A remove count larger than the full output slots is rejected, leaving the counters unchanged, and sets the error flag with type 8.
- R7: Config bit 1 enables coalescing. Config bits 15:8 hold a count threshold, where 0 acts as 1. With coalescing on, the interrupt sets when the completions since the last interrupt reach the threshold.
- R8: Config bits 31:16 hold a timer threshold. With coalescing on and at least one completion waiting, the interrupt sets once the timer passes the threshold. The timer restarts on every interrupt.
- R9: With config bit 2 set, no job issues while the error flag is set. Issuing resumes once the flag is cleared.
- R10: Writing 1 to command bit 0 sets the halt state to 1 and stops issue. The halt state becomes 2 once no job is in flight. A further command write in state 2 clears indices, counters and the interrupt, and returns the halt state to 0. A command write in state 1 sets the error flag with type 7.
- R11: Config bit 0 masks the irq output without changing the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| job_issue | output | 1 | One-cycle pulse per job dispatched |
| job_done | input | 1 | Completion strobe from the execution engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives doorbell counts that overrun each ring by one or more entries. A design that compared against the wrong bound, or updated the counters before rejecting, would report a wrong error type or a shifted room or slot count. It walks both indices past their ring sizes, where an off-by-one wrap would show as index 8 or 4 instead of 0. It holds a single completion below the count threshold to separate the count trigger from the timer trigger. It issues a reset command while a job is still in flight, so a design that skipped the drain would report halt complete too early or clear the rings without the second write.

// File: rtl/jr_pkg.sv
package jr_pkg;
  typedef enum logic [1:0] {
    HALT_IDLE = 2'd0,
    HALT_BUSY = 2'd1,
    HALT_DONE = 2'd2
  } halt_e;

  localparam logic [3:0] ERR_RESET   = 4'd7;
  localparam logic [3:0] ERR_REM_OVF = 4'd8;
  localparam logic [3:0] ERR_ADD_OVF = 4'd9;

  localparam int unsigned A_CFG   = 0;
  localparam int unsigned A_ISIZE = 1;
  localparam int unsigned A_OSIZE = 2;
  localparam int unsigned A_ADD   = 3;
  localparam int unsigned A_REM   = 4;
  localparam int unsigned A_STAT  = 5;
  localparam int unsigned A_RIDX  = 6;
  localparam int unsigned A_WIDX  = 7;
  localparam int unsigned A_CMD   = 8;
endpackage

// File: rtl/jr_ring_track.sv
module jr_ring_track #(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] in_size,
  input  logic [RW-1:0] out_size,
  input  logic          add_we,
  input  logic [RW-1:0] add_cnt,
  input  logic          rem_we,
  input  logic [RW-1:0] rem_cnt,
  input  logic          run,
  input  logic          job_done,
  input  logic          flush,
  output logic [RW-1:0] in_pend,
  output logic [RW-1:0] in_room,
  output logic [RW-1:0] out_full,
  output logic [RW-1:0] in_ridx,
  output logic [RW-1:0] out_widx,
  output logic [RW-1:0] inflight,
  output logic          issue,
  output logic          add_ovf,
  output logic          rem_ovf
);
  localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};

  logic          go, done_ok, add_ok, rem_ok;
  logic [RW:0]   busy_slots;

  always_comb begin
    in_room    = (in_size > in_pend) ? in_size - in_pend : '0;
    busy_slots = {1'b0, inflight} + {1'b0, out_full};
    go         = run && (in_pend != '0) && (busy_slots < {1'b0, out_size});
    done_ok    = job_done && (inflight != '0);
    add_ovf    = add_we && (add_cnt > in_room);
    rem_ovf    = rem_we && (rem_cnt > out_full);
    add_ok     = add_we && !add_ovf;
    rem_ok     = rem_we && !rem_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      in_pend  <= '0;
      out_full <= '0;
      in_ridx  <= '0;
      out_widx <= '0;
      inflight <= '0;
      issue    <= 1'b0;
    end else begin
      in_pend  <= in_pend + (add_ok ? add_cnt : '0) - (go ? ONE : '0);
      inflight <= inflight + (go ? ONE : '0) - (done_ok ? ONE : '0);
      out_full <= out_full + (done_ok ? ONE : '0) - (rem_ok ? rem_cnt : '0);
      issue    <= go;
      if (go)
        in_ridx <= (in_ridx + ONE >= in_size) ? '0 : in_ridx + ONE;
      if (done_ok)
        out_widx <= (out_widx + ONE >= out_size) ? '0 : out_widx + ONE;
    end
  end
endmodule

// File: rtl/jr_irq_coalesce.sv
module jr_irq_coalesce #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             coal_en,
  input  logic [CNT_W-1:0] cnt_th,
  input  logic [TMR_W-1:0] tmr_th,
  input  logic             clr,
  input  logic             flush,
  output logic             int_flag
);
  logic [CNT_W-1:0] pend;
  logic [CNT_W-1:0] th_eff;
  logic [CNT_W:0]   pend_inc;
  logic [TMR_W-1:0] tmr;
  logic             fire;

  always_comb begin
    th_eff   = (cnt_th == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cnt_th;
    pend_inc = {1'b0, pend} + {{CNT_W{1'b0}}, done};
    if (!coal_en)
      fire = done;
    else
      fire = (done && (pend_inc >= {1'b0, th_eff})) ||
             ((pend != '0) && (tmr >= tmr_th));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend     <= '0;
      tmr      <= '0;
      int_flag <= 1'b0;
    end else begin
      if (fire) begin
        pend <= '0;
        tmr  <= '0;
      end else begin
        pend <= pend_inc[CNT_W-1:0];
        if (pend != '0) tmr <= tmr + 1'b1;
      end
      if (fire)     int_flag <= 1'b1;
      else if (clr) int_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/jr_halt_ctl.sv
module jr_halt_ctl
  import jr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd,
  input  logic  idle,
  output halt_e state,
  output logic  flush,
  output logic  busy_err
);
  always_comb begin
    flush    = cmd && (state == HALT_DONE);
    busy_err = cmd && (state == HALT_BUSY);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= HALT_IDLE;
    else begin
      case (state)
        HALT_IDLE: if (cmd)  state <= HALT_BUSY;
        HALT_BUSY: if (idle) state <= HALT_DONE;
        HALT_DONE: if (cmd)  state <= HALT_IDLE;
        default:             state <= HALT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/job_ring_ctrl.sv
module job_ring_ctrl
  import jr_pkg::*;
#(
  parameter int RING_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              job_issue,
  input  logic              job_done,
  output logic              irq
);
  localparam int DATA_W  = 32;
  localparam int CNT_LSB = 8;
  localparam int TMR_LSB = 16;
  localparam int CNT_W   = TMR_LSB - CNT_LSB;
  localparam int TMR_W   = DATA_W - TMR_LSB;

  logic              cfg_mask, cfg_coal, cfg_soe;
  logic [CNT_W-1:0]  cfg_cnt;
  logic [TMR_W-1:0]  cfg_tmr;
  logic [RING_W-1:0] in_size, out_size;
  logic              err_flag;
  logic [3:0]        err_type;

  logic [RING_W-1:0] in_pend, in_room, out_full, in_ridx, out_widx, inflight;
  logic              add_ovf, rem_ovf, int_flag, flush, busy_err, run;
  logic              add_we, rem_we, cmd_we, clr_int, clr_err;
  halt_e             halt_state;
  logic [DATA_W-1:0] status, rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned sel);
    return a == ADDR_W'(sel);
  endfunction

  always_comb begin
    add_we  = reg_wr && hit(reg_addr, A_ADD);
    rem_we  = reg_wr && hit(reg_addr, A_REM);
    cmd_we  = reg_wr && hit(reg_addr, A_CMD) && reg_wdata[0];
    clr_int = reg_wr && hit(reg_addr, A_STAT) && reg_wdata[0];
    clr_err = reg_wr && hit(reg_addr, A_STAT) && reg_wdata[1];
    run     = (halt_state == HALT_IDLE) && !(cfg_soe && err_flag);
  end

  jr_ring_track #(.RW(RING_W)) u_track (
    .clk(clk), .rst(rst), .in_size(in_size), .out_size(out_size),
    .add_we(add_we), .add_cnt(reg_wdata[RING_W-1:0]),
    .rem_we(rem_we), .rem_cnt(reg_wdata[RING_W-1:0]),
    .run(run), .job_done(job_done), .flush(flush),
    .in_pend(in_pend), .in_room(in_room), .out_full(out_full),
    .in_ridx(in_ridx), .out_widx(out_widx), .inflight(inflight),
    .issue(job_issue), .add_ovf(add_ovf), .rem_ovf(rem_ovf)
  );

  jr_irq_coalesce #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_coal (
    .clk(clk), .rst(rst), .done(job_done && (inflight != '0)),
    .coal_en(cfg_coal), .cnt_th(cfg_cnt), .tmr_th(cfg_tmr),
    .clr(clr_int), .flush(flush), .int_flag(int_flag)
  );

  jr_halt_ctl u_halt (
    .clk(clk), .rst(rst), .cmd(cmd_we), .idle(inflight == '0),
    .state(halt_state), .flush(flush), .busy_err(busy_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mask <= 1'b0; cfg_coal <= 1'b0; cfg_soe <= 1'b0;
      cfg_cnt  <= '0;   cfg_tmr  <= '0;
      in_size  <= '0;   out_size <= '0;
    end else if (reg_wr) begin
      if (hit(reg_addr, A_CFG)) begin
        cfg_mask <= reg_wdata[0];
        cfg_coal <= reg_wdata[1];
        cfg_soe  <= reg_wdata[2];
        cfg_cnt  <= reg_wdata[CNT_LSB +: CNT_W];
        cfg_tmr  <= reg_wdata[TMR_LSB +: TMR_W];
      end
      if (hit(reg_addr, A_ISIZE)) in_size  <= reg_wdata[RING_W-1:0];
      if (hit(reg_addr, A_OSIZE)) out_size <= reg_wdata[RING_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_type <= '0;
    end else if (add_ovf) begin
      err_flag <= 1'b1; err_type <= ERR_ADD_OVF;
    end else if (rem_ovf) begin
      err_flag <= 1'b1; err_type <= ERR_REM_OVF;
    end else if (busy_err) begin
      err_flag <= 1'b1; err_type <= ERR_RESET;
    end else if (clr_err) begin
      err_flag <= 1'b0; err_type <= '0;
    end
  end

  always_comb begin
    status = {20'd0, err_type, 4'd0, halt_state, err_flag, int_flag};
    rd_mux = '0;
    if      (hit(reg_addr, A_CFG))   rd_mux = {cfg_tmr, cfg_cnt, 5'd0, cfg_soe, cfg_coal, cfg_mask};
    else if (hit(reg_addr, A_ISIZE)) rd_mux = DATA_W'(in_size);
    else if (hit(reg_addr, A_OSIZE)) rd_mux = DATA_W'(out_size);
    else if (hit(reg_addr, A_ADD))   rd_mux = DATA_W'(in_room);
    else if (hit(reg_addr, A_REM))   rd_mux = DATA_W'(out_full);
    else if (hit(reg_addr, A_STAT))  rd_mux = status;
    else if (hit(reg_addr, A_RIDX))  rd_mux = DATA_W'(in_ridx);
    else if (hit(reg_addr, A_WIDX))  rd_mux = DATA_W'(out_widx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= (int_flag || err_flag) && !cfg_mask;
    end
  end
endmodule

// File: rtl/jr_ring_checker.sv
module jr_ring_checker
  import jr_pkg::*;
#(
  parameter int RW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          add_ovf,
  input logic          rem_ovf,
  input logic          err_flag,
  input logic [3:0]    err_type,
  input halt_e         halt_state,
  input logic          job_issue,
  input logic          cfg_mask,
  input logic          irq,
  input logic [RW-1:0] in_pend
);
  AST_ADD_REJECT: assert property (@(posedge clk) disable iff (rst)
    add_ovf |=> (err_flag && err_type == ERR_ADD_OVF));  // R5
  AST_REM_REJECT: assert property (@(posedge clk) disable iff (rst)
    (rem_ovf && !add_ovf) |=> (err_flag && err_type == ERR_REM_OVF));  // R6
  AST_HALT_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (halt_state != HALT_IDLE) |=> !job_issue);  // R10
  AST_HALT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    halt_state != 2'd3);  // R10
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_mask |=> !irq);  // R11
  AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (rst)
    job_issue |-> $past(in_pend != '0));  // R2
endmodule

bind job_ring_ctrl jr_ring_checker #(.RW(RING_W)) u_chk (
  .clk(clk), .rst(rst), .add_ovf(add_ovf), .rem_ovf(rem_ovf),
  .err_flag(err_flag), .err_type(err_type), .halt_state(halt_state),
  .job_issue(job_issue), .cfg_mask(cfg_mask), .irq(irq), .in_pend(in_pend)
);

// File: tb/tb_job_ring_ctrl.sv
module tb_job_ring_ctrl;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0, job_done = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              reg_rvalid, job_issue, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  job_ring_ctrl #(.RING_W(10), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .job_issue(job_issue), .job_done(job_done),
    .irq(irq)
  );

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data returns
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (exp_q.size() == 0) check_val("unexpected read", reg_rdata, 32'hxxxx_xxxx);
      else check_val(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(int a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); job_done = 1'b1;
    @(negedge clk); job_done = 1'b0;
  endtask

  task automatic chk_irq(logic e, string tag);
    check_val(tag, {31'd0, irq}, {31'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // reset state
    rd_exp(5, 32'h0, "R4 status after reset");
    rd_exp(3, 32'h0, "R1 room after reset");
    rd_exp(4, 32'h0, "R3 full after reset");
    rd_exp(6, 32'h0, "R2 rdidx after reset");
    rd_exp(7, 32'h0, "R3 widx after reset");
    chk_irq(1'b0, "R4 irq after reset");

    wr(1, 8); wr(2, 4);
    rd_exp(3, 8, "R1 room after size write");
    wr(3, 3); idle(6);
    rd_exp(6, 3, "R2 rdidx after three issues");
    rd_exp(3, 8, "R2 room after drain");
    done_pulse(); done_pulse(); done_pulse(); idle(3);
    rd_exp(4, 3, "R3 full after completions");
    rd_exp(7, 3, "R3 widx after completions");
    rd_exp(5, 32'h1, "R4 completion bit");
    chk_irq(1'b1, "R4 irq on completion");
    wr(5, 1); idle(3);
    chk_irq(1'b0, "R4 irq after clear");
    rd_exp(5, 32'h0, "R4 status after clear");

    // remove overflow
    wr(4, 5); idle(2);
    rd_exp(5, 32'h802, "R6 remove overflow code");
    rd_exp(4, 3, "R6 full unchanged");
    chk_irq(1'b1, "R4 irq on error");
    wr(5, 2);
    rd_exp(5, 32'h0, "R4 error cleared");

    // add overflow
    wr(3, 9); idle(2);
    rd_exp(5, 32'h902, "R5 add overflow code");
    idle(3);
    rd_exp(6, 3, "R5 rdidx unchanged");
    rd_exp(3, 8, "R5 room unchanged");
    wr(5, 2);
    wr(4, 3);
    rd_exp(4, 0, "R3 full after remove");

    // coalescing: count threshold 2, timer threshold 20
    wr(0, 32'h0014_0202);
    wr(3, 3); idle(6);
    done_pulse(); idle(3);
    chk_irq(1'b0, "R7 below count threshold");
    rd_exp(5, 32'h0, "R7 status below threshold");
    done_pulse(); idle(3);
    chk_irq(1'b1, "R7 count threshold reached");
    wr(5, 1); idle(2);
    done_pulse(); idle(5);
    chk_irq(1'b0, "R8 timer not yet expired");
    idle(30);
    chk_irq(1'b1, "R8 timer expiry");
    wr(5, 1);
    rd_exp(7, 2, "R3 widx wrap");
    rd_exp(6, 6, "R2 rdidx after six issues");
    wr(4, 3);

    // mask
    wr(0, 32'h1);
    wr(3, 1); idle(4);
    done_pulse(); idle(3);
    rd_exp(5, 32'h1, "R11 status set while masked");
    chk_irq(1'b0, "R11 irq masked");
    wr(5, 1); wr(4, 1);

    // stop on error
    wr(0, 32'h4);
    wr(4, 1);
    wr(3, 1); idle(5);
    rd_exp(6, 7, "R9 no issue while error");
    rd_exp(3, 7, "R9 room holds pending job");
    wr(5, 2); idle(4);
    rd_exp(6, 0, "R9 issue resumes, R2 rdidx wrap");
    done_pulse(); idle(2);
    rd_exp(7, 0, "R3 widx wrap to zero");
    wr(5, 1); wr(4, 1);

    // reset handshake
    wr(0, 32'h0);
    wr(3, 1); idle(4);
    wr(8, 1);
    rd_exp(5, 32'h4, "R10 halt in progress");
    wr(8, 1);
    rd_exp(5, 32'h706, "R10 command during halt");
    wr(5, 2);
    done_pulse(); idle(3);
    rd_exp(5, 32'h9, "R10 halt complete");
    rd_exp(4, 1, "R10 full before clear");
    wr(5, 1);
    wr(8, 1); idle(2);
    rd_exp(5, 32'h0, "R10 status after clear");
    rd_exp(6, 0, "R10 rdidx cleared");
    rd_exp(7, 0, "R10 widx cleared");
    rd_exp(4, 0, "R10 full cleared");
    rd_exp(3, 8, "R10 room restored");
    idle(4);
    if (exp_q.size() != 0) check_val("scoreboard drain", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule